// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory Reader

This block is the read side of a sequential-access configuration store. A step clock, driven by whatever device is being configured, walks an internal word address and bit index through a small stored image. In serial mode each active step delivers one bit on lane 0 of the data output. In parallel mode each active step delivers a whole word on all lanes. The data lanes come with a drive-enable flag, `data_oe`, that stands in for a tri-state buffer. While the flag is low the lanes read as zero.

Several readers can be chained. The active-low cascade output of one reader feeds the chip-select of the next, and all of them share the step clock and the data lines. A reader hands over once its image is used up. It then releases its data lanes and pulls its cascade output low, but only while it is still selected and not held in reset.

A single pin carries both reset and output enable, and a static select chooses which level of that pin means reset. In parallel mode a BUSY input acts as back-pressure: while it is high the presented word stays on the lanes and the position does not advance. BUSY has no effect in serial mode. The image is written through a simple load port before it is read.

Top module: `cfg_stream_reader`

## Requirements
- R1: While the reset function is active, the read position is forced to word 0, bit 0. `data_oe` is low, `data_out` is zero and `cas_out_n` is high.
- R2: With `rst_pol_high`=1, a high level on `rst_oe_in` means reset and a low level means output enabled. With `rst_pol_high`=0 the meaning of the two levels is swapped.
- R3: While `ce_n` is high, `standby` is high, `data_oe` is low, `cas_out_n` is high and the read position does not change. `standby` is low whenever `ce_n` is low.
- R4: In serial mode (`par_mode`=0), each clock edge with `ce_n` low and reset inactive advances one bit. Lane 0 presents the stored word's bits most-significant first (bit 7 down to bit 0), and lanes 7..1 are zero. After bit 0 the next edge moves to bit 7 of the following word.
- R5: In parallel mode (`par_mode`=1), each active clock edge advances one whole word, and the lanes present the current stored word unchanged.
- R6: In parallel mode, an edge with `busy`=1 neither changes the position nor changes the presented word. In serial mode `busy` is ignored.
- R7: The edge that consumes the last bit or word of the highest address marks the image as exhausted. From then on, further active edges do not move the position, and `data_oe` stays low until the next reset.
- R8: Once the image is exhausted, `cas_out_n` equals `ce_n` while reset is inactive. `cas_out_n` is high while reset is active, and it stays high after reset until the image is exhausted again.
- R9: Without a reset, the read position is kept while `ce_n` is high. Reading resumes from the same word and bit when `ce_n` returns low.
- R10: A clock edge with `load_en`=1 writes `load_data` into word `load_addr`. Later reads of that word return the new value.
- R11: `data_out` is all zeros whenever `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock from the device being configured |
| rst_n | input | 1 | Power-on reset, active low, clears the read position |
| rst_pol_high | input | 1 | 1: a high `rst_oe_in` means reset; 0: a low `rst_oe_in` means reset |
| rst_oe_in | input | 1 | Combined reset / output-enable pin |
| ce_n | input | 1 | Chip select, active low |
| busy | input | 1 | Parallel-mode stall request |
| par_mode | input | 1 | 0: serial, one bit per step; 1: parallel, one word per step |
| load_en | input | 1 | Write strobe for the image |
| load_addr | input | ADDR_W (4) | Word address to write |
| load_data | input | WORD_W (8) | Word value to write |
| data_out | output | WORD_W (8) | Data lanes; lane 0 carries the serial bit |
| data_oe | output | 1 | High when the data lanes are driven |
| cas_out_n | output | 1 | Cascade chip-select output to the next reader, active low |
| standby | output | 1 | High while the reader is deselected |

## Verification
The hardest state to reach from the ports is the chain handoff in serial mode. It needs eight times the depth of consecutive active edges with no reset in between, and a sparse random reset almost never allows that. A directed run therefore streams the whole image bit by bit with BUSY held high, to show that BUSY does not matter in serial mode. It then toggles chip-select to show that the cascade output follows it, and it checks that a reset takes the handoff back. Random traffic then mixes selects, rare resets, mode and polarity changes and BUSY stalls. In parallel mode this random traffic reaches exhaustion often.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_data;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/cfg_seq_counter.sv
module cfg_seq_counter
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_act,
  input  logic              step_en,
  input  rd_mode_e          mode,
  input  logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || reset_act) begin
      addr    <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else if (step_en && !done) begin
      if (mode == MODE_PARALLEL) begin
        if (!busy) begin
          if (addr == LAST_ADDR) done <= 1'b1;
          else                   addr <= addr + 1'b1;
        end
      end else if (bit_idx == LAST_BIT) begin
        bit_idx <= '0;
        if (addr == LAST_ADDR) done <= 1'b1;
        else                   addr <= addr + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_act |=> (addr == '0 && bit_idx == '0 && !done));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !reset_act) |=> ($stable(addr) && $stable(bit_idx) && $stable(done)));

  assert_busy_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PARALLEL && busy && !reset_act) |=> ($stable(addr) && $stable(done)));

  assert_exhausted_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reset_act) |=> (done && $stable(addr)));
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_rd_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_mode_e          mode,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              ce_act,
  input  logic              oe_act,
  input  logic              done,
  output logic [WORD_W-1:0] data_out,
  output logic              data_oe,
  output logic              cas_out_n,
  output logic              standby
);
  logic serial_bit;

  assign serial_bit = rd_word[BIT_W'(WORD_W - 1) - bit_idx];
  assign data_oe    = ce_act && oe_act && !done;
  assign cas_out_n  = !(done && ce_act && oe_act);
  assign standby    = !ce_act;

  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    if (g == 0) begin : g_lane0
      assign data_out[g] = data_oe &&
        ((mode == MODE_PARALLEL) ? rd_word[g] : serial_bit);
    end else begin : g_upper
      assign data_out[g] = data_oe && (mode == MODE_PARALLEL) && rd_word[g];
    end
  end

  assert_quiet_lanes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  assert_handoff_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_out_n |-> !data_oe);
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pol_high,
  input  logic              rst_oe_in,
  input  logic              ce_n,
  input  logic              busy,
  input  logic              par_mode,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] data_out,
  output logic              data_oe,
  output logic              cas_out_n,
  output logic              standby
);
  logic              reset_act, oe_act, ce_act, done;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] rd_word;
  rd_mode_e          mode;

  assign reset_act = rst_pol_high ? rst_oe_in : !rst_oe_in;
  assign oe_act    = !reset_act;
  assign ce_act    = !ce_n;
  assign mode      = rd_mode_e'(par_mode);

  cfg_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .rd_addr(addr), .rd_word(rd_word)
  );

  cfg_seq_counter #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_count (
    .clk(clk), .rst_n(rst_n), .reset_act(reset_act),
    .step_en(ce_act && oe_act), .mode(mode), .busy(busy),
    .addr(addr), .bit_idx(bit_idx), .done(done)
  );

  cfg_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_word(rd_word),
    .bit_idx(bit_idx), .ce_act(ce_act), .oe_act(oe_act), .done(done),
    .data_out(data_out), .data_oe(data_oe), .cas_out_n(cas_out_n),
    .standby(standby)
  );

  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_act |-> (!data_oe && cas_out_n));

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!data_oe && cas_out_n));
endmodule

// File: tb/test_cfg_stream_reader.sv
module test_cfg_stream_reader;
  localparam int DEPTH = 16;
  localparam int WW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b1, r_act = 1'b1, ce_n = 1'b1, busy = 1'b0, par = 1'b0;
  logic load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] data_out;
  logic data_oe, cas_out_n, standby, rst_oe_in;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] bm [DEPTH];
  int m_addr = 0, m_bit = 0;
  bit m_done = 1'b0;

  assign rst_oe_in = pol ? r_act : !r_act;
  always #10 clk = !clk;

  cfg_stream_reader i_cfg_stream_reader (
    .clk(clk), .rst_n(rst_n), .rst_pol_high(pol), .rst_oe_in(rst_oe_in),
    .ce_n(ce_n), .busy(busy), .par_mode(par), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data), .data_out(data_out),
    .data_oe(data_oe), .cas_out_n(cas_out_n), .standby(standby)
  );

  function automatic logic [7:0] exp_data(bit oe);
    if (!oe) return 8'h00;
    if (par) return bm[m_addr];
    return {7'b0, bm[m_addr][7-m_bit]};
  endfunction

  task automatic tick(input string tag);
    bit e_oe, e_ceo_n, e_sb;
    logic [7:0] e_d;
    #2;
    e_oe    = !ce_n && !r_act && !m_done;
    e_ceo_n = !(m_done && !ce_n && !r_act);
    e_sb    = ce_n;
    e_d     = exp_data(e_oe);
    checks++;
    if (data_oe !== e_oe || data_out !== e_d || cas_out_n !== e_ceo_n || standby !== e_sb) begin
      errors++;
      $display("FAIL %s data=%h/%h oe=%b/%b ceo_n=%b/%b standby=%b/%b (actual/expected)",
               tag, data_out, e_d, data_oe, e_oe, cas_out_n, e_ceo_n, standby, e_sb);
    end
    @(posedge clk);
    if (r_act) begin
      m_addr = 0; m_bit = 0; m_done = 1'b0;
    end else if (!ce_n && !m_done) begin
      if (par) begin
        if (!busy) begin
          if (m_addr == DEPTH-1) m_done = 1'b1; else m_addr++;
        end
      end else if (m_bit == 7) begin
        m_bit = 0;
        if (m_addr == DEPTH-1) m_done = 1'b1; else m_addr++;
      end else m_bit++;
    end
    #1;
  endtask

  task automatic load_word(input int a, input logic [7:0] d);
    load_en = 1'b1; load_addr = 4'(a); load_data = d;
    @(posedge clk); #1;
    load_en = 1'b0;
    bm[a] = d;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state with active-high polarity
    tick("R1");
    // R10: fill the image through the load port
    for (int i = 0; i < DEPTH; i++) load_word(i, 8'((i * 29 + 90) ^ (i << 4)));
    // R4: full serial stream, busy held high to show it is ignored (R6)
    r_act = 1'b0; ce_n = 1'b0; par = 1'b0; busy = 1'b1;
    for (int i = 0; i < DEPTH * 8; i++) tick("R4");
    // R7: exhausted, lanes released, handoff low
    tick("R7"); tick("R7");
    // R8: handoff follows chip select, reset clears it
    ce_n = 1'b1; tick("R8");
    ce_n = 1'b0; tick("R8");
    r_act = 1'b1; tick("R8");
    r_act = 1'b0; tick("R8");
    // R2: low polarity, pin high now means enabled
    r_act = 1'b1; pol = 1'b0; tick("R2");
    r_act = 1'b0; par = 1'b1; busy = 1'b0; tick("R2");
    // R6: parallel stalls
    for (int i = 0; i < 18; i++) begin
      busy = (i % 3) != 0;
      tick("R6");
    end
    // R5: parallel through exhaustion
    busy = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) tick("R5");
    // R9: position kept while deselected
    r_act = 1'b1; tick("R9");
    r_act = 1'b0; par = 1'b0;
    for (int i = 0; i < 11; i++) tick("R9");
    ce_n = 1'b1;
    for (int i = 0; i < 4; i++) tick("R3");
    ce_n = 1'b0;
    for (int i = 0; i < 8; i++) tick("R9");
    // R10: rewrite word 0, read it back in parallel
    r_act = 1'b1; tick("R10");
    load_word(0, 8'hC3);
    r_act = 1'b0; par = 1'b1; tick("R10");
    // R11 plus everything: random traffic
    for (int i = 0; i < 3000; i++) begin
      ce_n = ($urandom % 100) < 12;
      r_act = ($urandom % 100) < 1;
      busy = ($urandom % 100) < 30;
      if (r_act && ($urandom % 2) == 1) par = !par;
      if (r_act && ($urandom % 4) == 0) pol = !pol;
      tick("R11");
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule